// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Status Word

This block is the execute-stage arithmetic and logic unit of a small eight-bit controller core. It takes two byte operands, a five-bit operation code, the current status byte, a bit selector and, for the word operation, a sixteen-bit register pair with a six-bit unsigned immediate. Every clock edge it registers a result byte, a result pair and a new status byte.

The operations cover byte add with and without carry-in, subtract, negate, increment and decrement, bitwise AND/OR/XOR and complement, shifts and rotates through carry, arithmetic right shift, nibble exchange, an add of a small constant to a register pair, and single-bit moves between a byte and the status word. Instruction fetch, decode and the register file belong to the surrounding core. The core reads the registered outputs one cycle after it presents an operation.

Status byte bit positions (bit 7 down to bit 0): I interrupt enable, T bit-copy store, H half carry, S sign, V signed overflow, N negative, Z zero, C carry.

Top module: `status_alu`

## Requirements
- R1: Status bit 7 (I) leaves the block equal to its input value for every operation except code 19 (bit set) and code 20 (bit clear).
- R2: Codes 0 (add) and 1 (add with carry, carry-in = status bit 0) give a + b (+ C). C is the carry out of bit 7, H is the carry out of bit 3 and V is the signed overflow.
- R3: Code 2 (subtract) gives a − b. Code 7 (negate) gives 0 − a. C is the borrow out of bit 7, H is the borrow into bit 4, and V is the signed overflow.
- R4: Every flag-updating operation (codes 0–14 and 16) sets N to the result's top bit, Z to whether the result is all zeros, and S to N xor V.
- R5: Codes 3, 4 and 5 (AND, OR, XOR) and code 6 (complement) clear V. The logic ops keep C and H. Complement sets C and keeps H.
- R6: Code 8 (increment) and code 9 (decrement) keep C and H. V is set only for the results 0x80 and 0x7F respectively.
- R7: Code 10 (shift left) and code 12 (rotate left through C) load C from a bit 7 and H from a bit 3, and set V = N xor C. Rotate left moves the old C into bit 0.
- R8: Code 11 (logical right), code 13 (rotate right through C) and code 14 (arithmetic right, bit 7 kept) load C from a bit 0, set V = N xor C and keep H.
- R9: Code 15 swaps a[7:4] with a[3:0] and returns the status byte unchanged.
- R10: Code 16 adds the zero-extended immediate to the pair. Z covers all 16 result bits, C is the carry out of bit 15, V is set when bit 15 rises from 0 to 1, and the result byte is the low byte. Every other code returns the input pair unchanged.
- R11: Code 17 copies a[bit_sel] into T and returns a. Code 18 returns a with bit bit_sel replaced by T and the status byte unchanged.
- R12: Code 19 sets and code 20 clears the status bit numbered by bit_sel. Both return a.
- R13: Outputs are registered with one cycle of latency. A low synchronous reset clears all of them to zero.
- R14: Codes 21–31 return a, the input pair and the input status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 5 | Operation code |
| opnd_a | input | 8 | First byte operand (destination value) |
| opnd_b | input | 8 | Second byte operand |
| bit_sel | input | 3 | Bit number for bit-move and bit-set/clear codes |
| sreg_in | input | 8 | Current status byte |
| pair_in | input | 16 | Register pair for the word add |
| imm6 | input | 6 | Unsigned word-add immediate, 0 to 63 |
| res_out | output | 8 | Registered result byte |
| pair_out | output | 16 | Registered result pair |
| sreg_out | output | 8 | Registered new status byte |

## Verification
The block's only state is the output register. A fault in the carry chain, the half-carry or overflow terms, or the flag-select logic therefore shows up at the ports in the cycle right after the operation is presented, either as a wrong status bit or as a wrong result byte. The most informative stimuli are operands chosen to cross bit 3 and bit 7 boundaries and inputs whose status byte has C and H already set. With those, a flag that should have been kept but was overwritten appears immediately. Running every code with random operands, carry-in and bit numbers also catches faults where one code's flag rules are applied to another code.

// File: rtl/status_alu_pkg.sv
// Shared operation codes, status-bit positions and widths for the ALU.
// Assumes the status byte layout is fixed and decoded by the surrounding core.
package status_alu_pkg;

    localparam int DW  = 8;
    localparam int PW  = 16;
    localparam int IW  = 6;
    localparam int OPW = 5;
    localparam int SW  = $clog2(DW);

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_AND  = 5'd3,
        OP_OR   = 5'd4,  OP_XOR  = 5'd5,  OP_COM  = 5'd6,  OP_NEG  = 5'd7,
        OP_INC  = 5'd8,  OP_DEC  = 5'd9,  OP_LSL  = 5'd10, OP_LSR  = 5'd11,
        OP_ROL  = 5'd12, OP_ROR  = 5'd13, OP_ASR  = 5'd14, OP_SWAP = 5'd15,
        OP_ADIW = 5'd16, OP_BST  = 5'd17, OP_BLD  = 5'd18, OP_BSET = 5'd19,
        OP_BCLR = 5'd20
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    // True for codes that rewrite C, Z, N, V, S and H.
    function automatic logic sets_flags(input logic [OPW-1:0] code);
        return (code <= 5'd14) || (code == 5'd16);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
// Byte adder/subtractor with carry, half-carry and signed-overflow outputs.
// Assumes W is even; the half carry is taken at the nibble boundary W/2.
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         h,
    output logic         v
);
    localparam int HB = W/2 - 1;

    logic [W:0] full;
    logic       a3, b3, r3, a7, b7, r7;

    // Form the sum or difference with one extra bit for carry/borrow.
    always_comb begin
        if (sub) full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else     full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    assign r  = full[W-1:0];
    assign c  = full[W];
    assign a3 = a[HB];
    assign b3 = b[HB];
    assign r3 = r[HB];
    assign a7 = a[W-1];
    assign b7 = b[W-1];
    assign r7 = r[W-1];

    // Derive half carry and overflow from operand and result sign bits.
    always_comb begin
        if (sub) begin
            h = (~a3 & b3) | (b3 & r3) | (r3 & ~a3);
            v = (a7 & ~b7 & ~r7) | (~a7 & b7 & r7);
        end else begin
            h = (a3 & b3) | (b3 & ~r3) | (~r3 & a3);
            v = (a7 & b7 & ~r7) | (~a7 & ~b7 & r7);
        end
    end
endmodule

// File: rtl/alu_shifter.sv
// One-place shifts, rotates through carry, arithmetic right shift and
// nibble swap. Assumes op selects one of these codes; others pass a through.
module alu_shifter #(
    parameter int W = 8
) (
    input  status_alu_pkg::alu_op_e op,
    input  logic [W-1:0]            a,
    input  logic                    cin,
    output logic [W-1:0]            r,
    output logic                    cout
);
    import status_alu_pkg::*;
    localparam int HW = W/2;

    // Select the shifted byte and the bit that falls out into carry.
    always_comb begin
        r    = a;
        cout = cin;
        case (op)
            OP_LSL:  begin r = {a[W-2:0], 1'b0};   cout = a[W-1]; end
            OP_ROL:  begin r = {a[W-2:0], cin};    cout = a[W-1]; end
            OP_LSR:  begin r = {1'b0, a[W-1:1]};   cout = a[0];   end
            OP_ROR:  begin r = {cin, a[W-1:1]};    cout = a[0];   end
            OP_ASR:  begin r = {a[W-1], a[W-1:1]}; cout = a[0];   end
            OP_SWAP: begin r = {a[HW-1:0], a[W-1:HW]};            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_word_add.sv
// Adds a zero-extended small immediate to a register pair.
// Assumes IW < PW; carry is the carry out of the top pair bit.
module alu_word_add #(
    parameter int PW = 16,
    parameter int IW = 6
) (
    input  logic [PW-1:0] pair,
    input  logic [IW-1:0] imm,
    output logic [PW-1:0] sum,
    output logic          c,
    output logic          v
);
    logic [PW:0] full;

    // Widen both operands and add.
    always_comb full = {1'b0, pair} + {{(PW-IW+1){1'b0}}, imm};

    assign sum = full[PW-1:0];
    assign c   = ~sum[PW-1] & pair[PW-1];
    assign v   = sum[PW-1] & ~pair[PW-1];
endmodule

// File: rtl/status_alu.sv
// Top of the ALU: picks the result for the operation code, assembles the
// new status byte and registers all outputs. Assumes op, operands and
// status are stable before each rising edge; reset is synchronous, active low.
module status_alu
    import status_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opnd_a,
    input  logic [DW-1:0]  opnd_b,
    input  logic [SW-1:0]  bit_sel,
    input  logic [DW-1:0]  sreg_in,
    input  logic [PW-1:0]  pair_in,
    input  logic [IW-1:0]  imm6,
    output logic [DW-1:0]  res_out,
    output logic [PW-1:0]  pair_out,
    output logic [DW-1:0]  sreg_out
);
    alu_op_e       op_e;
    logic [DW-1:0] as_a, as_b, as_r, sh_r, res_c, sr_c;
    logic          as_cin, as_sub, as_c, as_h, as_v, sh_c;
    logic [PW-1:0] wd_sum, pair_c;
    logic          wd_c, wd_v;
    logic          fc, fh, fv, fn, fz;

    assign op_e = alu_op_e'(op);

    // Route operands into the shared adder for add, sub, neg, inc, dec.
    always_comb begin
        as_a   = opnd_a;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op_e)
            OP_ADC: as_cin = sreg_in[FL_C];
            OP_SUB: as_sub = 1'b1;
            OP_NEG: begin as_a = '0; as_b = opnd_a; as_sub = 1'b1; end
            OP_INC: as_b = DW'(1);
            OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.W(DW)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .c(as_c), .h(as_h), .v(as_v)
    );

    alu_shifter #(.W(DW)) u_shift (
        .op(op_e), .a(opnd_a), .cin(sreg_in[FL_C]), .r(sh_r), .cout(sh_c)
    );

    alu_word_add #(.PW(PW), .IW(IW)) u_word (
        .pair(pair_in), .imm(imm6), .sum(wd_sum), .c(wd_c), .v(wd_v)
    );

    // Choose the result and the per-code carry, half-carry and overflow.
    always_comb begin
        res_c  = opnd_a;
        pair_c = pair_in;
        sr_c   = sreg_in;
        fc     = sreg_in[FL_C];
        fh     = sreg_in[FL_H];
        fv     = sreg_in[FL_V];
        case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
                res_c = as_r; fc = as_c; fh = as_h; fv = as_v;
            end
            OP_INC, OP_DEC: begin res_c = as_r; fv = as_v; end
            OP_AND: begin res_c = opnd_a & opnd_b; fv = 1'b0; end
            OP_OR:  begin res_c = opnd_a | opnd_b; fv = 1'b0; end
            OP_XOR: begin res_c = opnd_a ^ opnd_b; fv = 1'b0; end
            OP_COM: begin res_c = ~opnd_a; fv = 1'b0; fc = 1'b1; end
            OP_LSL, OP_ROL: begin
                res_c = sh_r; fc = sh_c; fh = opnd_a[DW/2-1];
                fv = sh_r[DW-1] ^ sh_c;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                res_c = sh_r; fc = sh_c; fv = sh_r[DW-1] ^ sh_c;
            end
            OP_SWAP: res_c = sh_r;
            OP_ADIW: begin
                res_c = wd_sum[DW-1:0]; pair_c = wd_sum; fc = wd_c; fv = wd_v;
            end
            OP_BST:  sr_c[FL_T] = opnd_a[bit_sel];
            OP_BLD:  res_c[bit_sel] = sreg_in[FL_T];
            OP_BSET: sr_c[bit_sel] = 1'b1;
            OP_BCLR: sr_c[bit_sel] = 1'b0;
            default: ;
        endcase
        fn = (op_e == OP_ADIW) ? wd_sum[PW-1] : res_c[DW-1];
        fz = (op_e == OP_ADIW) ? (wd_sum == '0) : (res_c == '0);
        if (sets_flags(op)) begin
            sr_c[FL_C] = fc;
            sr_c[FL_Z] = fz;
            sr_c[FL_N] = fn;
            sr_c[FL_V] = fv;
            sr_c[FL_S] = fn ^ fv;
            sr_c[FL_H] = fh;
        end
    end

    // Register the outputs; synchronous clear when reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out  <= '0;
            pair_out <= '0;
            sreg_out <= '0;
        end else begin
            res_out  <= res_c;
            pair_out <= pair_c;
            sreg_out <= sr_c;
        end
    end

    // R4
    sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sets_flags($past(op)))
        |-> (sreg_out[FL_S] == (sreg_out[FL_N] ^ sreg_out[FL_V])));

    // R9
    swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_SWAP) |-> (sreg_out == $past(sreg_in)));

    // R1
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) != OP_BSET && $past(op) != OP_BCLR)
        |-> (sreg_out[FL_I] == $past(sreg_in[FL_I])));

    // R10
    word_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_ADIW)
        |-> ({sreg_out[FL_C], pair_out} == ({1'b0, $past(pair_in)} + 17'($past(imm6)))));

    // R5
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) == OP_AND || $past(op) == OP_OR || $past(op) == OP_XOR))
        |-> (!sreg_out[FL_V] && sreg_out[FL_C] == $past(sreg_in[FL_C])
             && sreg_out[FL_H] == $past(sreg_in[FL_H])));
endmodule

// File: tb/status_alu_test.sv
module status_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [7:0]  opnd_a = '0, opnd_b = '0, sreg_in = '0;
    logic [2:0]  bit_sel = '0;
    logic [15:0] pair_in = '0;
    logic [5:0]  imm6 = '0;
    logic [7:0]  res_out, sreg_out;
    logic [15:0] pair_out;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    status_alu uut (
        .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .bit_sel(bit_sel), .sreg_in(sreg_in), .pair_in(pair_in), .imm6(imm6),
        .res_out(res_out), .pair_out(pair_out), .sreg_out(sreg_out)
    );

    // Expected {pair, status, result} from the requirement text.
    function automatic logic [31:0] model(input logic [4:0] o, input logic [7:0] a,
            input logic [7:0] b, input logic [2:0] bs, input logic [7:0] sr,
            input logic [15:0] pr, input logic [5:0] im);
        logic [7:0] r; logic [15:0] p; logic [7:0] s;
        logic c, h, v, n, z, upd, cin; logic [8:0] t; logic [16:0] w;
        r = a; p = pr; s = sr; c = sr[0]; h = sr[5]; v = sr[3]; upd = 1'b1;
        w = '0; cin = 1'b0;
        case (o)
            5'd0, 5'd1: begin
                cin = (o == 5'd1) ? sr[0] : 1'b0;
                t = a + b + cin; r = t[7:0]; c = t[8];
                h = ((a & 15) + (b & 15) + cin) > 15;
                v = (a[7] == b[7]) && (r[7] != a[7]);
            end
            5'd2: begin
                r = a - b; c = b > a; h = (b & 15) > (a & 15);
                v = (a[7] != b[7]) && (r[7] != a[7]);
            end
            5'd7: begin r = -a; c = a != 0; h = (a & 15) != 0; v = a == 8'h80; end
            5'd8: begin r = a + 1; v = a == 8'h7f; end
            5'd9: begin r = a - 1; v = a == 8'h80; end
            5'd3: begin r = a & b; v = 1'b0; end
            5'd4: begin r = a | b; v = 1'b0; end
            5'd5: begin r = a ^ b; v = 1'b0; end
            5'd6: begin r = ~a; v = 1'b0; c = 1'b1; end
            5'd10: begin r = a << 1; c = a[7]; h = a[3]; v = r[7] ^ c; end
            5'd12: begin r = {a[6:0], sr[0]}; c = a[7]; h = a[3]; v = r[7] ^ c; end
            5'd11: begin r = a >> 1; c = a[0]; v = r[7] ^ c; end
            5'd13: begin r = {sr[0], a[7:1]}; c = a[0]; v = r[7] ^ c; end
            5'd14: begin r = {a[7], a[7:1]}; c = a[0]; v = r[7] ^ c; end
            5'd15: begin r = {a[3:0], a[7:4]}; upd = 1'b0; end
            5'd16: begin
                w = pr + im; p = w[15:0]; r = w[7:0]; c = w[16];
                v = !pr[15] && w[15];
            end
            5'd17: begin s[6] = a[bs]; upd = 1'b0; end
            5'd18: begin r[bs] = sr[6]; upd = 1'b0; end
            5'd19: begin s[bs] = 1'b1; upd = 1'b0; end
            5'd20: begin s[bs] = 1'b0; upd = 1'b0; end
            default: upd = 1'b0;
        endcase
        n = (o == 5'd16) ? w[15] : r[7];
        z = (o == 5'd16) ? (w[15:0] == 0) : (r == 0);
        if (upd) begin
            s[0] = c; s[1] = z; s[2] = n; s[3] = v; s[4] = n ^ v; s[5] = h;
        end
        return {p, s, r};
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1: return "R2";
            5'd2, 5'd7: return "R3";
            5'd3, 5'd4, 5'd5, 5'd6: return "R5";
            5'd8, 5'd9: return "R6";
            5'd10, 5'd12: return "R7";
            5'd11, 5'd13, 5'd14: return "R8";
            5'd15: return "R9";
            5'd16: return "R10";
            5'd17, 5'd18: return "R11";
            5'd19, 5'd20: return "R12";
            default: return "R14";
        endcase
    endfunction

    // Drive at a falling edge, check the registered outputs one falling edge later.
    task automatic apply(input string tag, input logic [4:0] o, input logic [7:0] a,
            input logic [7:0] b, input logic [2:0] bs, input logic [7:0] sr,
            input logic [15:0] pr, input logic [5:0] im);
        logic [31:0] exp, got;
        op = o; opnd_a = a; opnd_b = b; bit_sel = bs; sreg_in = sr;
        pair_in = pr; imm6 = im;
        exp = model(o, a, b, bs, sr, pr, im);
        @(negedge clk);
        got = {pair_out, sreg_out, res_out};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h sr=%h got=%h exp=%h",
                     tag, o, a, b, sr, got, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        op = 5'd0; opnd_a = 8'hFF; opnd_b = 8'hFF; sreg_in = 8'hFF; pair_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R13: reset clears every output
        checks++;
        if ({pair_out, sreg_out, res_out} !== 32'h0) begin
            failures++;
            $display("FAIL R13 reset got=%h exp=%h", {pair_out, sreg_out, res_out}, 32'h0);
        end
        rst_n = 1'b1;
        apply("R13", 5'd0, 8'h12, 8'h34, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R2",  5'd0, 8'h0F, 8'h01, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R2",  5'd0, 8'h7F, 8'h01, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R2",  5'd0, 8'hFF, 8'h01, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R2",  5'd1, 8'hFF, 8'h00, 3'd0, 8'h01, 16'h0, 6'd0);
        apply("R3",  5'd2, 8'h00, 8'h01, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R3",  5'd2, 8'h80, 8'h01, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R3",  5'd7, 8'h80, 8'h00, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R3",  5'd7, 8'h00, 8'h00, 3'd0, 8'h3F, 16'h0, 6'd0);
        apply("R4",  5'd2, 8'h55, 8'h55, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R6",  5'd8, 8'h7F, 8'h00, 3'd0, 8'h21, 16'h0, 6'd0);
        apply("R6",  5'd9, 8'h80, 8'h00, 3'd0, 8'h21, 16'h0, 6'd0);
        apply("R5",  5'd3, 8'hF0, 8'h0F, 3'd0, 8'h29, 16'h0, 6'd0);
        apply("R5",  5'd6, 8'hFF, 8'h00, 3'd0, 8'h20, 16'h0, 6'd0);
        apply("R7",  5'd10, 8'h88, 8'h00, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R7",  5'd12, 8'h40, 8'h00, 3'd0, 8'h01, 16'h0, 6'd0);
        apply("R8",  5'd13, 8'h01, 8'h00, 3'd0, 8'h21, 16'h0, 6'd0);
        apply("R8",  5'd14, 8'h81, 8'h00, 3'd0, 8'h00, 16'h0, 6'd0);
        apply("R8",  5'd11, 8'h01, 8'h00, 3'd0, 8'h20, 16'h0, 6'd0);
        apply("R9",  5'd15, 8'hA5, 8'h00, 3'd0, 8'hFF, 16'h0, 6'd0);
        apply("R10", 5'd16, 8'h00, 8'h00, 3'd0, 8'h00, 16'hFFC1, 6'd63);
        apply("R10", 5'd16, 8'h00, 8'h00, 3'd0, 8'h00, 16'h7FFF, 6'd1);
        apply("R10", 5'd0,  8'h01, 8'h02, 3'd0, 8'h00, 16'hBEEF, 6'd5);
        apply("R11", 5'd17, 8'h08, 8'h00, 3'd3, 8'h00, 16'h0, 6'd0);
        apply("R11", 5'd18, 8'h00, 8'h00, 3'd5, 8'h40, 16'h0, 6'd0);
        apply("R12", 5'd19, 8'h00, 8'h00, 3'd7, 8'h00, 16'h0, 6'd0);
        apply("R12", 5'd20, 8'h00, 8'h00, 3'd0, 8'hFF, 16'h0, 6'd0);
        apply("R1",  5'd0,  8'h10, 8'h20, 3'd0, 8'h80, 16'h0, 6'd0);
        apply("R14", 5'd25, 8'h3C, 8'hC3, 3'd2, 8'h5A, 16'h1234, 6'd9);
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] ro;
            ro = 5'($urandom_range(0, 31));
            apply(tag_of(ro), ro, 8'($urandom), 8'($urandom), 3'($urandom),
                  8'($urandom), 16'($urandom), 6'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule